// File: doc/BRIEF.md
# Sequential Radix-4 Signed Multiplier

This block multiplies two N-bit two's-complement operands over several clock cycles and returns a 2N-bit signed product. It reads the multiplier two bits at a time. Each bit pair, together with the bit just below it, is turned into a digit from the set {-2, -1, 0, +1, +2}. Each digit chooses one multiple of the multiplicand: zero, the multiplicand, twice it, or the negative of either. That multiple is added into a running sum on a single adder, and the sum then shifts right by two places to meet the next digit. Because every step consumes two multiplier bits, an N-bit operation takes N/2 steps. No three-times multiple is ever needed.

A user pulses `start` with both operands while the unit is idle. `busy` stays high while the steps run. `done` marks the cycle in which the product becomes valid. The product then stays unchanged until the next accepted start. N must be even.

Top module: `r4_seq_mult`

## Requirements
- R1: While reset is asserted and right after it is released, `busy` and `done` are 0 and `product` is all zeros.
- R2: `start` is accepted only when `busy` is 0. A `start` pulse while `busy` is 1 has no effect on the operands in use, on the result or on the timing.
- R3: After `start` is accepted on a clock edge, `busy` is 1 from that edge on. `busy` falls and `done` rises exactly N/2 clock edges later, and the step counter advances by one on each of those edges.
- R4: `done` is high for exactly one clock cycle per operation.
- R5: When `done` is 1, `product` equals the signed product of `op_a` and `op_b` as sampled at the accepting edge, written as a 2N-bit two's-complement value. This includes the cases most-negative times most-negative, zero, and -1.
- R6: Once an operation completes, `product` keeps its value until the next accepted `start`, whatever the operand inputs do.
- R7: The multiplier bits {b[2i+1], b[2i], b[2i-1]}, with b[-1] = 0, are recoded as follows: 000 and 111 give 0; 001 and 010 give +1; 011 gives +2; 100 gives -2; 101 and 110 give -1. The value added in each step, including its carry-in, equals that digit times the multiplicand. Negative multiples are formed by inverting the multiplicand and adding a carry-in of 1.
- R8: The running sum carries two guard bits above the N-bit upper half. At completion those guard bits equal the product's sign bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an operation, honoured only while idle |
| op_a | input | N | Multiplicand, two's complement |
| op_b | input | N | Multiplier, two's complement |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: product is valid |
| product | output | 2N | Signed double-width result |

## Verification
The bench builds the block with N = 6. That makes all 4096 operand pairs cheap to run, so every recoded digit pattern in every digit position is exercised. The corner cases -32 × -32, zero and -1 fall inside this sweep. It also gives three steps per operation, which is enough to see the first-step, middle-step and last-step behaviour of the sequencer. Busy-time start pulses and long idle periods with changing operands are added on top of the sweep.

// File: rtl/r4mul_pkg.sv
package r4mul_pkg;

  // One recoded base-4 digit: magnitude 0, 1 or 2 plus a sign.
  typedef struct packed {
    logic zero;  // digit is 0
    logic neg;   // digit is negative
    logic dbl;   // magnitude is 2 (otherwise 1 when not zero)
  } r4_digit_t;

  // Overlapping-triplet recoding of the multiplier.
  function automatic r4_digit_t recode_triplet(input logic [2:0] t);
    r4_digit_t d;
    d.zero = (t == 3'b000) || (t == 3'b111);
    d.neg  = t[2] && !d.zero;
    d.dbl  = (t == 3'b011) || (t == 3'b100);
    return d;
  endfunction

  // Signed integer weight of a digit, for checking.
  function automatic int digit_weight(input r4_digit_t d);
    int m;
    m = d.zero ? 0 : (d.dbl ? 2 : 1);
    return d.neg ? -m : m;
  endfunction

endpackage

// File: rtl/r4_recoder.sv
module r4_recoder
  import r4mul_pkg::*;
(
  input  logic [2:0] triplet,
  output r4_digit_t  digit
);

  always_comb digit = recode_triplet(triplet);

  // R7: the digit weight matches the arithmetic weight -2*t2 + t1 + t0
  always_comb begin
    if (!$isunknown(triplet)) begin
      assert_digit_weight_R7: assert (digit_weight(digit) ==
        (-2 * int'(triplet[2]) + int'(triplet[1]) + int'(triplet[0])))
        else $error("recoded digit weight mismatch");
    end
  end

endmodule

// File: rtl/r4_multiple_sel.sv
module r4_multiple_sel
  import r4mul_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] mcand,
  input  r4_digit_t    digit,
  output logic [N+1:0] addend,
  output logic         cin
);

  localparam int AW = N + 2;

  logic [AW-1:0] mag;

  always_comb begin
    if (digit.dbl) mag = {mcand[N-1], mcand, 1'b0};
    else           mag = {{2{mcand[N-1]}}, mcand};
    if (digit.zero)     addend = '0;
    else if (digit.neg) addend = ~mag;
    else                addend = mag;
    cin = digit.neg;
  end

  // R7: addend plus carry-in equals the digit times the multiplicand
  always_comb begin
    if (!$isunknown({mcand, digit})) begin
      assert_multiple_value_R7: assert (AW'(addend + AW'(cin)) ==
        AW'(digit_weight(digit) * int'($signed(mcand))))
        else $error("selected multiple has wrong value");
    end
  end

endmodule

// File: rtl/r4_acc_path.sv
module r4_acc_path #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         last,
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  input  logic [N+1:0] addend,
  input  logic         cin,
  output logic [N-1:0] mcand,
  output logic [2:0]   triplet,
  output logic [2*N-1:0] product
);

  localparam int HW = N + 2;       // upper half plus two guard bits
  localparam int FW = HW + N;      // whole shift register

  logic [HW-1:0] hi_q;
  logic [N-1:0]  lo_q;
  logic          xb_q;             // multiplier bit just below the current pair
  logic [HW-1:0] sum;
  logic [FW-1:0] shifted;

  always_comb begin
    sum     = hi_q + addend + HW'(cin);
    shifted = FW'($signed({sum, lo_q}) >>> 2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      xb_q  <= 1'b0;
      mcand <= '0;
    end else if (load) begin
      hi_q  <= '0;
      lo_q  <= op_b;
      xb_q  <= 1'b0;
      mcand <= op_a;
    end else if (step) begin
      hi_q  <= shifted[FW-1:N];
      lo_q  <= shifted[N-1:0];
      xb_q  <= lo_q[1];
    end
  end

  assign triplet = {lo_q[1:0], xb_q};
  assign product = {hi_q[N-1:0], lo_q};

  // R2: an accepted start clears the sum and takes in the new multiplier
  assert_load_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (hi_q == '0) && !xb_q && (lo_q == $past(op_b)));

  // R6: without load or step the result does not move
  assert_product_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(product));

  // R8: guard bits equal the sign after the final step
  assert_guard_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (hi_q[N+1] == hi_q[N-1]) && (hi_q[N] == hi_q[N-1]));

endmodule

// File: rtl/r4_seq_ctrl.sv
module r4_seq_ctrl #(
  parameter int N = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic busy,
  output logic done
);

  localparam int STEPS = N / 2;
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic [CW-1:0] cnt_q;

  assign load = start && !busy;
  assign step = busy;
  assign last = busy && (cnt_q == CW'(STEPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end else if (last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (busy) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R4: done never lasts two cycles
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: done arrives as busy drops
  assert_done_ends_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R3: the step counter advances once per busy cycle
  assert_step_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (cnt_q == CW'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/r4_seq_mult.sv
module r4_seq_mult
  import r4mul_pkg::*;
#(
  parameter int N = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   op_a,
  input  logic [N-1:0]   op_b,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);

  logic          load_w;
  logic          step_w;
  logic          last_w;
  logic [N-1:0]  mcand_w;
  logic [2:0]    triplet_w;
  r4_digit_t     digit_w;
  logic [N+1:0]  addend_w;
  logic          cin_w;

  r4_seq_ctrl #(.N(N)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load_w),
    .step  (step_w),
    .last  (last_w),
    .busy  (busy),
    .done  (done)
  );

  r4_recoder u_rec (
    .triplet (triplet_w),
    .digit   (digit_w)
  );

  r4_multiple_sel #(.N(N)) u_sel (
    .mcand  (mcand_w),
    .digit  (digit_w),
    .addend (addend_w),
    .cin    (cin_w)
  );

  r4_acc_path #(.N(N)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_w),
    .step    (step_w),
    .last    (last_w),
    .op_a    (op_a),
    .op_b    (op_b),
    .addend  (addend_w),
    .cin     (cin_w),
    .mcand   (mcand_w),
    .triplet (triplet_w),
    .product (product)
  );

  // R2: a start during busy does not restart the sequence
  assert_busy_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last_w) |=> busy);

endmodule

// File: tb/r4_seq_mult_test.sv
`timescale 1ns/1ps
module r4_seq_mult_test;

  localparam int N     = 6;
  localparam int W     = 2 * N;
  localparam int STEPS = N / 2;
  localparam int LO    = -(1 << (N - 1));
  localparam int HI    = (1 << (N - 1)) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] op_a = '0;
  logic [N-1:0] op_b = '0;
  logic         busy;
  logic         done;
  logic [W-1:0] product;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  r4_seq_mult #(.N(N)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_a    (op_a),
    .op_b    (op_b),
    .busy    (busy),
    .done    (done),
    .product (product)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One operation; intrude=1 raises start with other operands while busy.
  task automatic mul(input int av, input int bv, input bit intrude);
    int lat;
    int exp;
    exp = av * bv;
    @(negedge clk);
    start = 1'b1;
    op_a  = N'(av);
    op_b  = N'(bv);
    @(negedge clk);
    start = 1'b0;
    op_a  = ~op_a;
    op_b  = op_b ^ N'(5);
    lat   = 1;
    chk(busy == 1'b1, "R3 busy after accept", longint'(busy), 1);
    if (intrude) begin
      start = 1'b1;
      op_a  = N'(HI);
      op_b  = N'(LO);
    end
    while (!done && lat < 20) begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    chk(lat == STEPS + 1, intrude ? "R2 R3 latency" : "R3 latency", lat, STEPS + 1);
    chk(product == W'(exp), intrude ? "R2 R5 product" : "R5 R7 product",
        longint'($signed(product)), exp);
    chk(busy == 1'b0, "R3 busy low at done", longint'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R4 done single cycle", longint'(done), 0);
    chk(product == W'(exp), "R6 product held", longint'($signed(product)), exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 flags in reset", longint'({busy, done}), 0);
    chk(product == '0, "R1 product in reset", longint'(product), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 flags after reset", longint'({busy, done}), 0);
    chk(product == '0, "R1 product after reset", longint'(product), 0);

    // named corner cases first
    mul(LO, LO, 1'b0);
    mul(0, LO, 1'b0);
    mul(-1, -1, 1'b0);
    mul(-1, HI, 1'b0);

    // exhaustive sweep, covers every digit pattern (R7)
    for (int a = LO; a <= HI; a++) begin
      for (int b = LO; b <= HI; b++) begin
        mul(a, b, 1'b0);
      end
    end

    // start pulses while busy are ignored (R2)
    mul(LO, -1, 1'b1);
    mul(13, -22, 1'b1);
    mul(-7, 3, 1'b1);

    // long idle with moving operands: result held (R6)
    mul(-19, 27, 1'b0);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      op_a = N'(k * 7);
      op_b = N'(k * 3 + 1);
      chk(product == W'(-19 * 27), "R6 idle hold", longint'($signed(product)), -19 * 27);
      chk(busy == 1'b0 && done == 1'b0, "R6 idle flags", longint'({busy, done}), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule